// File: doc/BRIEF.md
# Gated Serial Byte Transmitter

This block is the transmit half of an asynchronous serial port. A host writes bytes through a small register-write port. The bytes queue in a 16-entry holding FIFO. A frame engine takes each byte and sends it on the serial output line as one start bit (low), eight data bits with the least significant bit first, and one stop bit (high). The line sits high while nothing is being sent. A programmable divider sets the bit rate. It turns the bus clock into an oversample tick, and each serial bit lasts sixteen ticks.

A transmit-enable bit controls when a queued byte may pass from the FIFO into the frame engine. Software clears the bit when the far end asks it to pause and sets it again when the far end is ready, which gives XON/XOFF flow control. Clearing the bit never cuts off a character that has already started. That character always finishes, stop bit included, and every later byte waits in the FIFO until the bit is set again.

The frame engine has four states: `TXS_IDLE`, `TXS_START`, `TXS_DATA` and `TXS_STOP`. Its transitions are:
- load: `TXS_IDLE` to `TXS_START`, taken when the enable bit is 1 and the FIFO holds a byte.
- start-done: `TXS_START` to `TXS_DATA`.
- data-done: `TXS_DATA` to `TXS_STOP`, taken after the eighth data bit.
- frame-done: `TXS_STOP` to `TXS_IDLE`.

Each of start-done, data-done and frame-done happens on the 16th tick of the current bit.

Top module: `uart_tx_gated`

## Requirements
- R1: Reset state: `txd`=1, `tx_idle`=1, `ctl_q`=8'h80 (the enable bit resets to 1), `overflow`=0 and `empty_pulse`=0.
- R2: Frame format: start bit 0, then 8 data bits sent LSB first, then stop bit 1. The line is 1 whenever no frame is in progress.
- R3: Bit timing. The divisor is the 16-bit value {address 2 byte, address 1 byte}. One oversample tick occurs every divisor clocks, and a divisor of 0 acts as 1. Each serial bit lasts 16 ticks.
- R4: Bytes written to address 0 are sent in the order they were written. The FIFO holds up to 16 bytes.
- R5: A write to address 0 while the FIFO is full and no byte leaves in that cycle is dropped, and `overflow` is set. `overflow` then stays 1 until reset.
- R6: Address 3 is the control register. Bit 7 is the transmit enable. Writes to bits 6:0 are ignored, and those bits read back as 0 on `ctl_q`.
- R7: While the enable bit is 0, no byte moves from the FIFO into the frame engine, so no start bit begins.
- R8: If the enable bit is cleared while a character is being sent, that character still completes, including its stop bit.
- R9: When the enable bit is set again, sending resumes with the oldest waiting byte, and no byte is lost.
- R10: `empty_pulse` is high for exactly one cycle each time the FIFO goes from holding bytes to empty. If a write and a hand-off happen in the same cycle, both take effect, the occupancy does not change, and no pulse is raised.
- R11: `tx_idle` is 1 exactly when the FIFO is empty and the frame engine is in `TXS_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 divisor low byte, 2 divisor high byte, 3 control |
| wr_data | input | 8 | Write data |
| txd | output | 1 | Serial output line |
| ctl_q | output | 8 | Control register readback: {enable, 7'b0} |
| overflow | output | 1 | Sticky flag for a dropped write |
| empty_pulse | output | 1 | One-cycle pulse when the FIFO becomes empty |
| tx_idle | output | 1 | High when the FIFO is empty and no frame is in progress |

## Verification
Two events can fall in the same clock edge: a host write into the FIFO and the frame engine taking a byte out of it. The bench provokes this with the divisor at 1 and the line idle. It writes two bytes on back-to-back cycles, so the second write lands on the same edge as the load of the first byte. The bench judges the outcome in two ways. Both bytes must be decoded from the line in order. Exactly one `empty_pulse` must be seen, and it must come when the second byte leaves the FIFO, not at the collision.

// File: rtl/uart_txg_pkg.sv
package uart_txg_pkg;

    typedef enum logic [1:0] {
        TXS_IDLE,
        TXS_START,
        TXS_DATA,
        TXS_STOP
    } txs_e;

    localparam logic [1:0] REG_DATA   = 2'd0;
    localparam logic [1:0] REG_DIV_LO = 2'd1;
    localparam logic [1:0] REG_DIV_HI = 2'd2;
    localparam logic [1:0] REG_CTL    = 2'd3;

endpackage

// File: rtl/txg_baud.sv
module txg_baud #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] div_eff;

    // a zero divisor behaves like one so the tick never stalls
    assign div_eff = (div == '0) ? DW'(1) : div;
    assign tick    = (cnt >= div_eff - DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + DW'(1);
    end
endmodule

// File: rtl/txg_fifo.sv
module txg_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       drop,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign dout    = mem[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/txg_shift.sv
module txg_shift
    import uart_txg_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 en,
    input  logic                 have_data,
    input  logic [DATA_BITS-1:0] din,
    output logic                 pop,
    output logic                 txd,
    output logic                 busy,
    output txs_e                 state
);
    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(DATA_BITS);

    txs_e                 nxt;
    logic [TW-1:0]        tcnt;
    logic [BW-1:0]        bidx;
    logic [DATA_BITS-1:0] sh;
    logic                 last_tick;

    assign pop       = (state == TXS_IDLE) && en && have_data;
    assign last_tick = tick && (tcnt == TW'(OSR-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXS_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            TXS_IDLE:  if (pop)       nxt = TXS_START;
            TXS_START: if (last_tick) nxt = TXS_DATA;
            TXS_DATA:  if (last_tick && bidx == BW'(DATA_BITS-1)) nxt = TXS_STOP;
            TXS_STOP:  if (last_tick) nxt = TXS_IDLE;
        endcase
    end

    // bit and tick counters, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            bidx <= '0;
            sh   <= '0;
        end else if (pop) begin
            tcnt <= '0;
            bidx <= '0;
            sh   <= din;
        end else if (state != TXS_IDLE && tick) begin
            tcnt <= last_tick ? '0 : tcnt + TW'(1);
            if (state == TXS_DATA && last_tick) begin
                sh   <= sh >> 1;
                bidx <= bidx + BW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            TXS_IDLE:  begin txd = 1'b1;  busy = 1'b0; end
            TXS_START: begin txd = 1'b0;  busy = 1'b1; end
            TXS_DATA:  begin txd = sh[0]; busy = 1'b1; end
            TXS_STOP:  begin txd = 1'b1;  busy = 1'b1; end
        endcase
    end
endmodule

// File: rtl/uart_tx_gated.sv
module uart_tx_gated
    import uart_txg_pkg::*;
#(
    parameter int          DEPTH     = 16,
    parameter logic [15:0] DIV_RESET = 16'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       txd,
    output logic [7:0] ctl_q,
    output logic       overflow,
    output logic       empty_pulse,
    output logic       tx_idle
);
    localparam int DATA_BITS = 8;
    localparam int OSR       = 16;
    localparam int DIV_W     = 16;
    localparam int CW        = $clog2(DEPTH+1);

    logic [DIV_W-1:0]     div_q;
    logic                 en_q, ovf_q, empty_q;
    logic                 tick, fifo_empty, fifo_drop, sh_pop, sh_busy;
    logic [DATA_BITS-1:0] fifo_dout;
    logic [CW-1:0]        fifo_cnt;
    logic                 push;
    txs_e                 sh_state;

    assign push = wr_en && (wr_addr == REG_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= DIV_RESET;
            en_q    <= 1'b1;
            ovf_q   <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            empty_q <= fifo_empty;
            if (fifo_drop) ovf_q <= 1'b1;
            if (wr_en) begin
                unique case (wr_addr)
                    REG_DIV_LO: div_q[7:0]  <= wr_data;
                    REG_DIV_HI: div_q[15:8] <= wr_data;
                    REG_CTL:    en_q        <= wr_data[7];
                    default:    ;
                endcase
            end
        end
    end

    txg_baud #(.DW(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (div_q),
        .tick (tick)
    );

    txg_fifo #(.W(DATA_BITS), .DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .din  (wr_data),
        .pop  (sh_pop),
        .dout (fifo_dout),
        .empty(fifo_empty),
        .drop (fifo_drop),
        .count(fifo_cnt)
    );

    txg_shift #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (en_q),
        .have_data(!fifo_empty),
        .din      (fifo_dout),
        .pop      (sh_pop),
        .txd      (txd),
        .busy     (sh_busy),
        .state    (sh_state)
    );

    assign ctl_q       = {en_q, 7'b0};
    assign overflow    = ovf_q;
    assign empty_pulse = fifo_empty && !empty_q;
    assign tx_idle     = fifo_empty && !sh_busy;
endmodule

// File: rtl/uart_tx_gated_chk.sv
module uart_tx_gated_chk
    import uart_txg_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       txd,
    input logic                       tx_idle,
    input logic                       empty_pulse,
    input logic                       overflow,
    input logic                       en,
    input logic                       pop,
    input txs_e                       state,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd); // R2
    AST_STOP_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        state == TXS_STOP |=> state inside {TXS_STOP, TXS_IDLE}); // R2
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R5
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && state == TXS_IDLE) |=> state == TXS_IDLE); // R7
    AST_POP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> en); // R7
    AST_CHAR_NOT_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
        state == TXS_DATA |=> state inside {TXS_DATA, TXS_STOP}); // R8
    AST_EMPTY_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        empty_pulse |=> !empty_pulse); // R10
endmodule

bind uart_tx_gated uart_tx_gated_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txd        (txd),
    .tx_idle    (tx_idle),
    .empty_pulse(empty_pulse),
    .overflow   (overflow),
    .en         (en_q),
    .pop        (sh_pop),
    .state      (sh_state),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/tb_uart_tx_gated.sv
module tb_uart_tx_gated;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       txd, overflow, empty_pulse, tx_idle;
    logic [7:0] ctl_q;

    int   checks = 0;
    int   fails = 0;
    int   cur_div = 1;
    int   pulse_cnt = 0;
    logic en_m = 1'b1;
    logic ovf_m = 1'b0;
    bit   mon_on = 1'b0;
    logic [7:0] expq[$];

    always #5 clk = ~clk;

    uart_tx_gated dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .txd(txd), .ctl_q(ctl_q), .overflow(overflow),
        .empty_pulse(empty_pulse), .tx_idle(tx_idle)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of register state against the model
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            chk(ctl_q == {en_m, 7'b0}, "R6", "ctl_q per-cycle", ctl_q, {en_m, 7'b0});
            chk(overflow == ovf_m, "R5", "overflow per-cycle", overflow, ovf_m);
            if (empty_pulse) pulse_cnt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // called at a falling edge; the write is captured by the next rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a == 2'd3) en_m = d[7];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] d);
        expq.push_back(d);
        wr(2'd0, d);
    endtask

    task automatic set_div(input logic [15:0] d);
        wr(2'd1, d[7:0]);
        wr(2'd2, d[15:8]);
        cur_div = (d == 16'd0) ? 1 : int'(d);
    endtask

    task automatic wait_start(input string req);
        int n = 0;
        while (txd !== 1'b0 && n < 60000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 60000) chk(1'b0, req, "start bit timeout", txd, 0);
    endtask

    task automatic rx_byte(input string req);
        logic [7:0] b;
        logic [7:0] exp;
        wait_start(req);
        repeat (8 * cur_div) @(negedge clk);
        chk(txd == 1'b0, "R2", "start bit level", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (16 * cur_div) @(negedge clk);
            b[i] = txd;
        end
        repeat (16 * cur_div) @(negedge clk);
        chk(txd == 1'b1, req, "stop bit level", txd, 1);
        exp = (expq.size() > 0) ? expq.pop_front() : 8'hxx;
        chk(b === exp, req, "decoded byte", b, exp);
    endtask

    task automatic hold_quiet(input int n, input string req);
        bit low_seen = 1'b0;
        bit idle_seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd == 1'b0) low_seen = 1'b1;
            if (tx_idle) idle_seen = 1'b1;
        end
        chk(!low_seen, req, "line stayed high while held", low_seen, 0);
        chk(!idle_seen, "R11", "tx_idle low while bytes wait", idle_seen, 0);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
        chk(tx_idle == 1'b1, "R1", "tx_idle after reset", tx_idle, 1);
        chk(ctl_q == 8'h80, "R1", "ctl_q after reset", ctl_q, 8'h80);
        chk(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
        chk(empty_pulse == 1'b0, "R1", "empty_pulse after reset", empty_pulse, 0);
        mon_on = 1'b1;

        // R2 and R3: frame format at divisor 3
        set_div(16'd3);
        push_byte(8'h5A);
        rx_byte("R2");
        repeat (20 * cur_div) @(negedge clk);
        chk(tx_idle == 1'b1, "R11", "idle after frame", tx_idle, 1);

        // R3: divisor 0 behaves as 1
        set_div(16'd0);
        push_byte(8'hC3);
        rx_byte("R3");
        repeat (40) @(negedge clk);

        // R6: reserved bits ignored
        wr(2'd3, 8'hFF);
        chk(ctl_q == 8'h80, "R6", "reserved bits read zero", ctl_q, 8'h80);
        wr(2'd3, 8'h7F);
        chk(ctl_q == 8'h00, "R6", "bits 6:0 do not set enable", ctl_q, 8'h00);

        // R4, R5, R7: fill while disabled, overflow, then drain in order
        set_div(16'd1);
        for (int i = 0; i < 16; i++) push_byte(8'(i * 13 + 7));
        chk(overflow == 1'b0, "R5", "no overflow at exactly full", overflow, 0);
        ovf_m = 1'b1;
        wr(2'd0, 8'hEE);
        chk(overflow == 1'b1, "R5", "overflow after write to full", overflow, 1);
        hold_quiet(300, "R7");
        wr(2'd3, 8'h80);
        for (int i = 0; i < 16; i++) rx_byte("R4");
        hold_quiet_done: begin
            bit low_seen = 1'b0;
            repeat (40) @(negedge clk);
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (txd == 1'b0) low_seen = 1'b1;
            end
            chk(!low_seen, "R5", "dropped byte never sent", low_seen, 0);
            chk(tx_idle == 1'b1, "R11", "idle after drain", tx_idle, 1);
        end

        // R10: write lands on the same edge as the hand-off
        pulse_cnt = 0;
        push_byte(8'h11);
        push_byte(8'h22);
        rx_byte("R10");
        rx_byte("R10");
        repeat (40) @(negedge clk);
        chk(pulse_cnt == 1, "R10", "empty pulses over collision", pulse_cnt, 1);

        // R8, R9: clear enable mid-character, then resume
        set_div(16'd2);
        push_byte(8'h3C);
        push_byte(8'h96);
        fork
            rx_byte("R8");
            begin
                wait_start("R8");
                repeat (100) @(negedge clk);
                wr(2'd3, 8'h00);
            end
        join
        hold_quiet(600, "R7");
        wr(2'd3, 8'h80);
        rx_byte("R9");
        repeat (20 * cur_div) @(negedge clk);
        chk(tx_idle == 1'b1, "R11", "idle at end", tx_idle, 1);
        chk(expq.size() == 0, "R9", "no byte left unsent", expq.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule